// File: doc/BRIEF.md
# ATM Cell Payload Scrambler (x^43 + 1, self-synchronous)

This block sits on the transmit side of a cell-based link and whitens the payload portion of each ATM cell before it is mapped into a line frame. It takes one byte per clock with a valid flag and a flag that marks the byte as payload or header. Payload bytes are scrambled with the self-synchronous x^43 + 1 polynomial. Each transmitted bit is the incoming bit XORed with the transmitted bit 43 positions earlier in the scrambled stream. Header bytes go through unaltered, and the scrambler history skips over them. A receiver running the matching descrambler can therefore recover the payload without any alignment exchange.

Scrambling is the normal state. It can be turned off from two places: a configuration bit driven by a software-visible register, and a test pin. Either one alone is enough. When neither is asserted, which is the condition after reset, every valid payload byte is scrambled. Bypassed bytes leave the history untouched, so scrambling picks up again where it left off. Every output is registered, and the latency is one clock in all modes.

Top module: `atm_payload_scrambler`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, out_valid is 0 and out_data is 0x00. Reset also clears the 43-bit history to all zeros.
- R2: For a valid payload byte with both bypass controls low, the bits are taken MSB first (bit 7 first). Each output bit equals the input bit XOR the scrambled output bit 43 positions earlier. The bit stream runs on across consecutive scrambled bytes.
- R3: If cfg_scr_disable or test_scr_bypass is 1, or both are, out_data equals in_data unchanged.
- R4: A byte bypassed under R3 does not advance the history. Scrambling of later bytes continues as if the bypassed bytes had never been presented.
- R5: A valid byte with in_payload = 0 (header) is output unchanged and does not advance the history.
- R6: In a cycle with in_valid = 0, the history does not change. One cycle later out_valid is 0, and out_data carries in_data from that cycle.
- R7: out_valid and out_data reflect the inputs sampled at the previous rising clock edge, giving one cycle of latency in every mode.
- R8: With both bypass controls held low, which is the post-reset default, scrambling is active without any further action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Cell byte to transmit |
| in_valid | input | 1 | in_data holds a byte this cycle |
| in_payload | input | 1 | 1 = payload byte, 0 = header byte |
| cfg_scr_disable | input | 1 | Register bit that disables scrambling when 1 |
| test_scr_bypass | input | 1 | Test pin that disables scrambling when 1 |
| out_data | output | 8 | Scrambled or passed-through byte, registered |
| out_valid | output | 1 | out_data holds a byte, registered |

## Verification
The properties assume that every input is a known 0 or 1 at each rising edge once reset has been released. They also assume that the bypass controls may change on any cycle, with no settling time after a change. The bench drives every input half a clock away from the sampling edge. It changes the bypass sources, the payload flag and the valid flag on arbitrary cycles, including mid-cell, and it applies a second reset mid-stream. This exercises history holding and the return to an all-zero history under those allowed conditions.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned POLY_LAG = 43;
endpackage

// File: rtl/scr_bypass_ctrl.sv
module scr_bypass_ctrl (
  input  logic in_valid,
  input  logic in_payload,
  input  logic sw_disable,
  input  logic pin_bypass,
  output logic scr_bypass,
  output logic scr_advance
);
  always_comb begin
    scr_bypass  = sw_disable | pin_bypass;
    scr_advance = in_valid & in_payload & ~scr_bypass;
  end
endmodule

// File: rtl/scr_byte_core.sv
module scr_byte_core #(
  parameter int unsigned DW  = 8,
  parameter int unsigned LAG = 43
) (
  input  logic [LAG-1:0] hist_i,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  dout,
  output logic [LAG-1:0] hist_o
);
  localparam int unsigned KEEP = LAG - DW;

  initial begin
    if (LAG <= DW) $error("scr_byte_core: LAG must exceed DW");
  end

  // hist_i[LAG-1] is the oldest bit; din[DW-1] is transmitted first.
  for (genvar k = 0; k < DW; k++) begin : g_bit
    assign dout[k] = din[k] ^ hist_i[k + KEEP];
  end

  assign hist_o = {hist_i[KEEP-1:0], dout};
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_scr,
  input  logic [DW-1:0] scr_data,
  input  logic [DW-1:0] raw_data,
  input  logic          vld_i,
  output logic [DW-1:0] data_o,
  output logic          vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      data_o <= sel_scr ? scr_data : raw_data;
      vld_o  <= vld_i;
    end
  end
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler
  import scr_pkg::*;
#(
  parameter int unsigned DW  = BYTE_W,
  parameter int unsigned LAG = POLY_LAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_payload,
  input  logic          cfg_scr_disable,
  input  logic          test_scr_bypass,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  logic           scr_bypass;
  logic           scr_advance;
  logic [DW-1:0]  scr_byte;
  logic [LAG-1:0] hist_q;
  logic [LAG-1:0] hist_d;

  scr_bypass_ctrl u_ctrl (
    .in_valid    (in_valid),
    .in_payload  (in_payload),
    .sw_disable  (cfg_scr_disable),
    .pin_bypass  (test_scr_bypass),
    .scr_bypass  (scr_bypass),
    .scr_advance (scr_advance)
  );

  scr_byte_core #(.DW(DW), .LAG(LAG)) u_core (
    .hist_i (hist_q),
    .din    (in_data),
    .dout   (scr_byte),
    .hist_o (hist_d)
  );

  always_ff @(posedge clk) begin
    if (rst)              hist_q <= '0;
    else if (scr_advance) hist_q <= hist_d;
  end

  scr_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .sel_scr  (scr_advance),
    .scr_data (scr_byte),
    .raw_data (in_data),
    .vld_i    (in_valid),
    .data_o   (out_data),
    .vld_o    (out_valid)
  );

  logic unused_bypass;
  assign unused_bypass = scr_bypass;
endmodule

// File: rtl/atm_payload_scrambler_chk.sv
module atm_payload_scrambler_chk #(
  parameter int unsigned DW  = 8,
  parameter int unsigned LAG = 43
) (
  input logic           clk,
  input logic           rst,
  input logic [DW-1:0]  in_data,
  input logic           in_valid,
  input logic           in_payload,
  input logic           cfg_scr_disable,
  input logic           test_scr_bypass,
  input logic [DW-1:0]  out_data,
  input logic           out_valid,
  input logic [LAG-1:0] hist_q
);
  // R1: first cycle after reset shows cleared outputs and history
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hist_q == '0 && !out_valid && out_data == '0));

  // R2: a scrambled byte becomes the newest history bits
  a_r2_hist_newest: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_payload && !cfg_scr_disable && !test_scr_bypass)
    |=> (hist_q[DW-1:0] == out_data));

  // R3, R4: bypass passes data and holds history
  a_r3_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (cfg_scr_disable || test_scr_bypass))
    |=> (out_data == $past(in_data)));
  a_r4_bypass_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_scr_disable || test_scr_bypass) |=> $stable(hist_q));

  // R5: header bytes untouched, history held
  a_r5_header_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_payload)
    |=> (out_data == $past(in_data) && $stable(hist_q)));

  // R6: idle cycles hold history and produce no valid output
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(hist_q)));

  // R7: one-cycle valid latency
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
endmodule

bind atm_payload_scrambler atm_payload_scrambler_chk #(.DW(DW), .LAG(LAG)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .in_data         (in_data),
  .in_valid        (in_valid),
  .in_payload      (in_payload),
  .cfg_scr_disable (cfg_scr_disable),
  .test_scr_bypass (test_scr_bypass),
  .out_data        (out_data),
  .out_valid       (out_valid),
  .hist_q          (hist_q)
);

// File: tb/atm_payload_scrambler_tb.sv
module atm_payload_scrambler_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_payload = 1'b0;
  logic       cfg_scr_disable = 1'b0;
  logic       test_scr_bypass = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit   hist[$];
  logic [7:0] exp_d;
  logic       exp_v;
  string      exp_tag;
  bit         have_exp = 1'b0;

  always #10 clk = ~clk;

  atm_payload_scrambler u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_payload(in_payload), .cfg_scr_disable(cfg_scr_disable),
    .test_scr_bypass(test_scr_bypass), .out_data(out_data), .out_valid(out_valid)
  );

  function automatic void model_reset();
    hist.delete();
    for (int i = 0; i < 43; i++) hist.push_back(1'b0);
  endfunction

  function automatic logic [7:0] model_scramble(logic [7:0] x);
    logic [7:0] y;
    for (int i = 7; i >= 0; i--) begin
      y[i] = x[i] ^ hist[0];
      void'(hist.pop_front());
      hist.push_back(y[i]);
    end
    return y;
  endfunction

  task automatic check_prev();
    if (have_exp) begin
      checks++;
      if (out_valid !== exp_v || out_data !== exp_d) begin
        failures++;
        $display("FAIL %s: out_valid/out_data actual=%0b/%02h expected=%0b/%02h",
                 exp_tag, out_valid, out_data, exp_v, exp_d);
      end
    end
  endtask

  task automatic step(input bit v, input bit p, input logic [7:0] d,
                      input bit dis, input bit pin, input string tag);
    @(negedge clk);
    check_prev();
    in_valid = v; in_payload = p; in_data = d;
    cfg_scr_disable = dis; test_scr_bypass = pin;
    exp_v = v;
    if (v && p && !dis && !pin) exp_d = model_scramble(d);
    else                        exp_d = d;
    exp_tag = tag;
    have_exp = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_prev();
    rst = 1'b1; in_valid = 1'b0;
    have_exp = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 8'h00) begin
      failures++;
      $display("FAIL R1: reset outputs actual=%0b/%02h expected=0/00", out_valid, out_data);
    end
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();
    // R1/R8: first payload after reset, zero history, default active
    for (int i = 0; i < 100; i++) step(1, 1, 8'($urandom), 0, 0, "R8 default scramble R2");
    // R2: fixed patterns
    for (int i = 0; i < 60; i++) step(1, 1, 8'hFF, 0, 0, "R2 all-ones");
    for (int i = 0; i < 60; i++) step(1, 1, 8'h80 >> (i % 8), 0, 0, "R2 walking bit");
    // R5: cells with 5 header bytes then 48 payload bytes
    for (int c = 0; c < 6; c++) begin
      for (int h = 0; h < 5; h++) step(1, 0, 8'($urandom), 0, 0, "R5 header");
      for (int b = 0; b < 48; b++) step(1, 1, 8'($urandom), 0, 0, "R5 payload after header");
    end
    // R3: each bypass source alone and both
    for (int i = 0; i < 30; i++) step(1, 1, 8'($urandom), 1, 0, "R3 register disable");
    for (int i = 0; i < 30; i++) step(1, 1, 8'($urandom), 0, 1, "R3 test pin");
    for (int i = 0; i < 30; i++) step(1, 1, 8'($urandom), 1, 1, "R3 both");
    // R4: resume after bypass, toggling bypass mid-stream
    for (int i = 0; i < 300; i++)
      step(1, 1, 8'($urandom), ($urandom % 5) == 0, ($urandom % 7) == 0, "R4 resume after bypass");
    // R6/R7: gaps in valid
    for (int i = 0; i < 300; i++)
      step(($urandom % 3) != 0, ($urandom % 6) != 0, 8'($urandom), 0, 0, "R6 R7 gaps");
    // R1: reset mid-stream restores zero history
    do_reset();
    for (int i = 0; i < 80; i++) step(1, 1, 8'($urandom), 0, 0, "R1 history cleared");
    // Mixed everything
    for (int i = 0; i < 1000; i++)
      step(($urandom % 4) != 0, ($urandom % 5) != 0, 8'($urandom),
           ($urandom % 9) == 0, ($urandom % 11) == 0, "R2 R3 R4 R5 R6 mixed");
    step(0, 0, 8'h00, 0, 0, "R7 drain");
    @(negedge clk);
    check_prev();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule